// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block chooses which of five interrupt sources a small microcontroller core services next, and when. The sources are external line 0, timer 0, external line 1, timer 1 and the serial port. The serial port raises a request when either its transmit flag or its receive flag is set. Each source has an enable bit, and a global enable bit gates all of them. A priority bit places each source at either the low level or the high level. Within one level a fixed order decides between sources.

The core pulses `insn_end` on the cycle its current instruction completes. At that boundary the controller can start a hardware call. It then asserts `call_req` for one cycle and places the handler address on `vec_addr`. On the same cycle it pulses a clear for the request flag of an external or timer source. The serial flags are never cleared here; their handler clears them.

Two level-active flags record which levels are in service, so a high-level source can interrupt a low-level handler once. The `reti` strobe ends the innermost handler.

A request may first appear during the late part of an instruction. The core shows that part with `late_win`. Such a request is not considered at that instruction's boundary, so one further instruction runs before the call. Stacking the program counter and sequencing the call belong to the core.

Top module: `irq2_ctrl`

## Requirements
- R1: After reset, `call_req` is 0, `flag_clr` is 0, `vec_addr` is 0x0000, and both `lvl_lo_act` and `lvl_hi_act` are 0.
- R2: A call is started only at the clock edge where `insn_end` is 1. It also needs `en_reg[7]` (global enable) set and the source's own enable bit set. The enable bit for source i is `en_reg[i]`: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. Bits 5 and 6 are ignored.
- R3: When a call starts, `call_req` is 1 for exactly the one cycle after that edge. `vec_addr` then holds 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for source 0, 1, 2, 3 or 4. `vec_addr` keeps that value until the next call.
- R4: Among requesting sources of the same level, the one with the lowest source index wins.
- R5: `pri_reg[i]` = 1 puts source i at the high level. A high-level candidate wins over any low-level candidate, whatever their indices.
- R6: No call starts while `lvl_hi_act` is 1. While only `lvl_lo_act` is 1, only high-level sources can start a call.
- R7: Starting a call sets `lvl_hi_act` for a high-level winner, or `lvl_lo_act` for a low-level winner. The flag is visible on the same cycle as `call_req`.
- R8: A `reti` pulse clears `lvl_hi_act` if it is set, and otherwise clears `lvl_lo_act`. The result is visible one cycle later.
- R9: With a call to source 0 to 3, `flag_clr[i]` is 1 for that same single cycle. `flag_clr[4]` stays 0: the serial flags are never cleared by the block.
- R10: Suppose `insn_end` comes while `late_win` is 1. Arbitration then uses the request state captured on the last cycle where `late_win` was 0. A request that first appears inside the window therefore waits for a later boundary.
- R11: The serial source requests when `ser_tx_req` or `ser_rx_req` is 1, and it is serviced the same way in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_req | input | 1 | External line 0 request flag |
| tmr0_req | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | External line 1 request flag |
| tmr1_req | input | 1 | Timer 1 overflow flag |
| ser_tx_req | input | 1 | Serial transmit-done flag |
| ser_rx_req | input | 1 | Serial receive-done flag |
| en_reg | input | 8 | Per-source enables in bits 0..4, global enable in bit 7 |
| pri_reg | input | 8 | Per-source high-level select in bits 0..4 |
| insn_end | input | 1 | Instruction boundary strobe |
| late_win | input | 1 | Current cycle lies in the late-request window |
| reti | input | 1 | Return-from-interrupt strobe |
| call_req | output | 1 | One-cycle hardware call request |
| vec_addr | output | 16 | Handler start address |
| flag_clr | output | 5 | Per-source request flag clear pulses |
| lvl_lo_act | output | 1 | Low-level handler in service |
| lvl_hi_act | output | 1 | High-level handler in service |

## Verification
The assertions take for granted that the core never pulses `reti` on the same cycle as `insn_end`. They also assume that an external or timer source drops its flag within one cycle of its clear pulse. The reset-state property assumes `insn_end` is held low while reset is applied. The stimulus keeps `reti` and boundary strobes on separate cycles and keeps `insn_end` low during reset. After each clear pulse it lowers the matching request on the next cycle, as a real timer or edge detector would. Serial flags are lowered only when the scenario's handler would do so.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  localparam int unsigned SRC_N     = 5;
  localparam int unsigned SRC_IDX_W = $clog2(SRC_N);

  typedef struct packed {
    logic                 valid;
    logic                 hi;
    logic [SRC_IDX_W-1:0] idx;
    logic [SRC_N-1:0]     onehot;
  } grant_t;
endpackage

// File: rtl/irq2_sampler.sv
module irq2_sampler #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic         hold,
  input  logic [N-1:0] drop,
  output logic [N-1:0] eff
);
  logic [N-1:0] held_q;

  // While the late window is open the boundary sees the last early snapshot.
  assign eff = hold ? held_q : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= eff & ~drop;
  end
endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter
  import irq2_pkg::*;
#(
  parameter int unsigned N     = SRC_N,
  parameter int unsigned IDX_W = SRC_IDX_W
) (
  input  logic [N-1:0]     cand_hi,
  input  logic [N-1:0]     cand_lo,
  input  logic             hi_act,
  input  logic             lo_act,
  output logic             gnt_valid,
  output logic             gnt_hi,
  output logic [IDX_W-1:0] gnt_idx,
  output logic [N-1:0]     gnt_onehot
);
  logic [N:0]   hi_below;
  logic [N:0]   lo_below;
  logic [N-1:0] hi_first;
  logic [N-1:0] lo_first;

  assign hi_below[0] = 1'b0;
  assign lo_below[0] = 1'b0;

  // Prefix chain: a bit wins if no lower index of the same level requests.
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign hi_first[i]   = cand_hi[i] & ~hi_below[i];
    assign lo_first[i]   = cand_lo[i] & ~lo_below[i];
    assign hi_below[i+1] = hi_below[i] | cand_hi[i];
    assign lo_below[i+1] = lo_below[i] | cand_lo[i];
  end

  logic hi_ok;
  logic lo_ok;
  assign hi_ok = !hi_act && hi_below[N];
  assign lo_ok = !hi_act && !lo_act && !hi_below[N] && lo_below[N];

  assign gnt_valid  = hi_ok || lo_ok;
  assign gnt_hi     = hi_ok;
  assign gnt_onehot = hi_ok ? hi_first : (lo_ok ? lo_first : '0);

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_onehot[i]) gnt_idx = gnt_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq2_level.sv
module irq2_level (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hi,
  input  logic set_lo,
  input  logic ret,
  output logic hi_act,
  output logic lo_act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_act <= 1'b0;
      lo_act <= 1'b0;
    end else begin
      if (set_hi)               hi_act <= 1'b1;
      else if (ret && hi_act)   hi_act <= 1'b0;
      if (set_lo)               lo_act <= 1'b1;
      else if (ret && !hi_act)  lo_act <= 1'b0;
    end
  end
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
  import irq2_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned GEN_BIT    = 7,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter logic [SRC_N-1:0] AUTOCLR = 5'b01111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext0_req,
  input  logic              tmr0_req,
  input  logic              ext1_req,
  input  logic              tmr1_req,
  input  logic              ser_tx_req,
  input  logic              ser_rx_req,
  input  logic [REG_W-1:0]  en_reg,
  input  logic [REG_W-1:0]  pri_reg,
  input  logic              insn_end,
  input  logic              late_win,
  input  logic              reti,
  output logic              call_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [SRC_N-1:0]  flag_clr,
  output logic              lvl_lo_act,
  output logic              lvl_hi_act
);
  logic [SRC_N-1:0]     raw;
  logic [SRC_N-1:0]     eff;
  logic [SRC_N-1:0]     drop;
  logic [SRC_N-1:0]     en_ok;
  logic [SRC_N-1:0]     cand_hi;
  logic [SRC_N-1:0]     cand_lo;
  logic                 gnt_valid;
  logic                 gnt_hi;
  logic [SRC_IDX_W-1:0] gnt_idx;
  logic [SRC_N-1:0]     gnt_onehot;
  logic                 take;
  logic                 unused_regs;

  assign unused_regs = ^{en_reg[REG_W-1:SRC_N], pri_reg[REG_W-1:SRC_N]};

  assign raw = {ser_tx_req | ser_rx_req, tmr1_req, ext1_req, tmr0_req, ext0_req};

  irq2_sampler #(.N(SRC_N)) u_samp (
    .clk(clk), .rst_n(rst_n), .raw(raw), .hold(late_win),
    .drop(drop), .eff(eff)
  );

  assign en_ok   = eff & en_reg[SRC_N-1:0] & {SRC_N{en_reg[GEN_BIT]}};
  assign cand_hi = en_ok & pri_reg[SRC_N-1:0];
  assign cand_lo = en_ok & ~pri_reg[SRC_N-1:0];

  irq2_arbiter #(.N(SRC_N), .IDX_W(SRC_IDX_W)) u_arb (
    .cand_hi(cand_hi), .cand_lo(cand_lo),
    .hi_act(lvl_hi_act), .lo_act(lvl_lo_act),
    .gnt_valid(gnt_valid), .gnt_hi(gnt_hi),
    .gnt_idx(gnt_idx), .gnt_onehot(gnt_onehot)
  );

  assign take = insn_end && gnt_valid;
  assign drop = take ? gnt_onehot : '0;

  irq2_level u_lvl (
    .clk(clk), .rst_n(rst_n),
    .set_hi(take && gnt_hi), .set_lo(take && !gnt_hi),
    .ret(reti), .hi_act(lvl_hi_act), .lo_act(lvl_lo_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_req <= 1'b0;
      vec_addr <= '0;
      flag_clr <= '0;
    end else begin
      call_req <= take;
      flag_clr <= take ? (gnt_onehot & AUTOCLR) : '0;
      if (take) vec_addr <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(gnt_idx));
    end
  end
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  en_reg,
  input logic        insn_end,
  input logic        reti,
  input logic        call_req,
  input logic [15:0] vec_addr,
  input logic [4:0]  flag_clr,
  input logic        lvl_lo_act,
  input logic        lvl_hi_act
);
  a_in_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(reti && insn_end));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !call_req && flag_clr == 5'b0 && !lvl_lo_act && !lvl_hi_act);

  a_r2_call_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_end |=> !call_req);

  a_r2_call_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    !en_reg[7] |=> !call_req);

  a_r3_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> vec_addr[2:0] == 3'd3 && vec_addr < 16'h0028);

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  a_r6_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hi_act |=> !call_req);

  a_r7_call_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> lvl_lo_act || lvl_hi_act);

  a_r8_reti_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    reti && lvl_hi_act |=> !lvl_hi_act && lvl_lo_act == $past(lvl_lo_act));

  a_r8_reti_lo: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !lvl_hi_act |=> !lvl_lo_act);

  a_r9_clear_with_call: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr != 5'b0 |-> call_req && $onehot0(flag_clr) && !flag_clr[4]);
endmodule

bind irq2_ctrl irq2_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .insn_end(insn_end),
  .reti(reti), .call_req(call_req), .vec_addr(vec_addr),
  .flag_clr(flag_clr), .lvl_lo_act(lvl_lo_act), .lvl_hi_act(lvl_hi_act)
);

// File: tb/irq2_ctrl_bench.sv
module irq2_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext0_req = 0, tmr0_req = 0, ext1_req = 0, tmr1_req = 0;
  logic ser_tx_req = 0, ser_rx_req = 0;
  logic [7:0] en_reg = 8'h00, pri_reg = 8'h00;
  logic insn_end = 0, late_win = 0, reti = 0;
  logic call_req;
  logic [15:0] vec_addr;
  logic [4:0] flag_clr;
  logic lvl_lo_act, lvl_hi_act;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq2_ctrl u_irq2_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext0_req(ext0_req), .tmr0_req(tmr0_req), .ext1_req(ext1_req),
    .tmr1_req(tmr1_req), .ser_tx_req(ser_tx_req), .ser_rx_req(ser_rx_req),
    .en_reg(en_reg), .pri_reg(pri_reg), .insn_end(insn_end),
    .late_win(late_win), .reti(reti), .call_req(call_req),
    .vec_addr(vec_addr), .flag_clr(flag_clr),
    .lvl_lo_act(lvl_lo_act), .lvl_hi_act(lvl_hi_act)
  );

  // Behavioural reference model.
  bit       m_call, m_hi, m_lo;
  int       m_vec;
  bit [4:0] m_clr, m_samp;

  always @(posedge clk) begin
    bit [4:0] raw, eff, ok;
    int win;
    bit win_hi, take;
    raw = {ser_tx_req | ser_rx_req, tmr1_req, ext1_req, tmr0_req, ext0_req};
    if (!rst_n) begin
      m_call <= 0; m_vec <= 0; m_clr <= 0; m_hi <= 0; m_lo <= 0; m_samp <= 0;
    end else begin
      eff = late_win ? m_samp : raw;
      ok = en_reg[7] ? (eff & en_reg[4:0]) : 5'b0;
      win = -1; win_hi = 0;
      if (!m_hi) begin
        for (int i = 4; i >= 0; i--) if (ok[i] && pri_reg[i]) begin win = i; win_hi = 1; end
        if (win < 0 && !m_lo)
          for (int i = 4; i >= 0; i--) if (ok[i] && !pri_reg[i]) win = i;
      end
      take = insn_end && win >= 0;
      m_call <= take;
      m_clr <= (take && win < 4) ? 5'(1 << win) : 5'b0;
      if (take) m_vec <= 3 + 8 * win;
      m_samp <= take ? (eff & ~5'(1 << win)) : eff;
      if (take && win_hi) m_hi <= 1;
      else if (reti && m_hi) m_hi <= 0;
      if (take && !win_hi) m_lo <= 1;
      else if (reti && !m_hi) m_lo <= 0;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, "call_req", int'(call_req), int'(m_call));
    chk(cur_req, "vec_addr", int'(vec_addr), m_vec);
    chk(cur_req, "flag_clr", int'(flag_clr), int'(m_clr));
    chk(cur_req, "lvl_hi_act", int'(lvl_hi_act), int'(m_hi));
    chk(cur_req, "lvl_lo_act", int'(lvl_lo_act), int'(m_lo));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare();
    if (flag_clr[0]) ext0_req = 0;
    if (flag_clr[1]) tmr0_req = 0;
    if (flag_clr[2]) ext1_req = 0;
    if (flag_clr[3]) tmr1_req = 0;
  endtask

  task automatic boundary();
    insn_end = 1; tick(); insn_end = 0;
  endtask

  task automatic do_reti();
    reti = 1; tick(); reti = 0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset call_req", int'(call_req), 0);
    chk("R1", "reset levels", int'({lvl_hi_act, lvl_lo_act}), 0);
    chk("R1", "reset vec", int'(vec_addr), 0);
    rst_n = 1; tick();

    // R2: no global enable, then no source enable, then both.
    cur_req = "R2";
    ext0_req = 1; en_reg = 8'h01; tick(); boundary();
    chk("R2", "no call without global", int'(call_req), 0);
    en_reg = 8'hFE; tick(); boundary();
    chk("R2", "no call without source bit", int'(call_req), 0);
    en_reg = 8'h9F; tick();
    chk("R2", "no call off boundary", int'(call_req), 0);
    boundary();
    chk("R2", "call taken", int'(call_req), 1);
    chk("R3", "vector ext0", int'(vec_addr), 16'h0003);
    chk("R9", "ext0 clear pulse", int'(flag_clr), 5'b00001);
    chk("R7", "low level set", int'(lvl_lo_act), 1);
    tick();
    chk("R3", "call one cycle", int'(call_req), 0);
    cur_req = "R8"; do_reti();
    chk("R8", "low level cleared", int'(lvl_lo_act), 0);

    // R3 and R9: every source alone, at low level.
    cur_req = "R3";
    for (int s = 0; s < 5; s++) begin
      ext0_req = (s == 0); tmr0_req = (s == 1); ext1_req = (s == 2);
      tmr1_req = (s == 3); ser_tx_req = (s == 4);
      tick(); boundary();
      chk("R3", "vector per source", int'(vec_addr), 3 + 8 * s);
      chk("R9", "clear per source", int'(flag_clr), s < 4 ? (1 << s) : 0);
      ser_tx_req = 0; tick(); do_reti();
    end

    // R4: fixed order within one level.
    cur_req = "R4";
    tmr1_req = 1; ext1_req = 1; ser_rx_req = 1; tick(); boundary();
    chk("R4", "ext1 before tmr1 and serial", int'(vec_addr), 16'h0013);
    tick(); do_reti(); boundary();
    chk("R4", "tmr1 next", int'(vec_addr), 16'h001B);
    tick(); do_reti();

    // R11: the receive flag alone reaches the serial vector.
    cur_req = "R11"; boundary();
    chk("R11", "serial via receive", int'(vec_addr), 16'h0023);
    chk("R11", "serial not cleared", int'(flag_clr), 0);
    ser_rx_req = 0; tick(); do_reti();

    // R5: a high-level serial request beats a low-level ext0.
    cur_req = "R5";
    pri_reg = 8'h10; ext0_req = 1; ser_tx_req = 1; tick(); boundary();
    chk("R5", "high level wins", int'(vec_addr), 16'h0023);
    chk("R5", "high flag", int'(lvl_hi_act), 1);
    ser_tx_req = 0; tick(); do_reti(); boundary();
    chk("R5", "low served after", int'(vec_addr), 16'h0003);
    tick(); do_reti();

    // R6: nesting.
    cur_req = "R6";
    pri_reg = 8'h04; tmr0_req = 1; tick(); boundary();
    chk("R6", "low handler", int'(vec_addr), 16'h000B);
    tmr1_req = 1; tick(); boundary();
    chk("R6", "low blocked by low", int'(call_req), 0);
    ext1_req = 1; tick(); boundary();
    chk("R6", "high preempts low", int'(vec_addr), 16'h0013);
    chk("R6", "both levels", int'({lvl_hi_act, lvl_lo_act}), 3);
    pri_reg = 8'h0C; tick(); boundary();
    chk("R6", "high blocked by high", int'(call_req), 0);
    cur_req = "R8"; do_reti();
    chk("R8", "high cleared first", int'({lvl_hi_act, lvl_lo_act}), 1);
    cur_req = "R6"; boundary();
    chk("R6", "high tmr1 under low", int'(vec_addr), 16'h001B);
    tick(); do_reti(); do_reti();
    chk("R8", "all clear", int'({lvl_hi_act, lvl_lo_act}), 0);
    pri_reg = 8'h00;

    // R10: late window.
    cur_req = "R10";
    tick(); late_win = 1; ext1_req = 1; boundary();
    chk("R10", "late arrival deferred", int'(call_req), 0);
    tick();
    chk("R10", "still deferred", int'(call_req), 0);
    late_win = 0; tick(); late_win = 1; boundary();
    chk("R10", "captured then served", int'(vec_addr), 16'h0013);
    chk("R10", "call", int'(call_req), 1);
    late_win = 0; tick(); do_reti();

    tick(); tick();
    finish_run();
  end
endmodule